// File: doc/BRIEF.md
# PLL Divider Word Calculator

This block turns the frequency of a PLL reference clock, given in hertz, into the 32-bit configuration word for a fractional-N PLL whose VCO must run at 2880 MHz. The VCO relation is FVCO = FREF x 2 x (NDIV + FRAC / 65536). The integer divider NDIV and the 16-bit fraction FRAC therefore come from one long division of 2880e6 x 65536 by 2 x FREF. The quotient's upper bits are NDIV and its lower 16 bits are FRAC.

A one-cycle start strobe samples the frequency. A reference outside the supported window is rejected at once, with an error flag and no new word. An accepted reference goes to a restoring divider that makes one quotient bit per clock. When the divider finishes, the block puts out NDIV, FRAC and the packed word, and pulses done. The packed word always carries the two dither-enable bits and the strobe-bypass bit. It carries the fraction field and the fraction-control bit only when the fraction is non-zero, and it never sets the PLL enable bit.

Top module: `pll_word_calc`

## Requirements
- R1: After reset, done and error are 0, NDIV and FRAC are 0, and the word is 0xD0000000.
- R2: For an accepted reference F, NDIV is floor(2880e6 / (2F)), appearing on the NDIV output and in word bits 6:0. A 24 MHz reference gives 60 and a 19.2 MHz reference gives 75.
- R3: FRAC is floor(65536 x frac-part(2880e6 / (2F))), appearing on the FRAC output and, when non-zero, in word bits 25:10. A 38.4 MHz reference gives NDIV 37 and FRAC 0x8000.
- R4: Word bits 31, 30 and 28 are always 1 and bit 26 is always 0.
- R5: Word bit 29 is 1 exactly when FRAC is non-zero. When FRAC is zero, bits 29 and 25:10 are all 0.
- R6: A reference below 19 200 000 or above 38 400 000 makes done and error both go high for one cycle, in the cycle after the start edge. NDIV, FRAC and the word keep their previous values. Both bounds themselves are accepted.
- R7: For an accepted reference sampled at clock edge k, done rises after edge k+48 for exactly one cycle with error low, and the results change at that same edge.
- R8: A start sampled while a division is in progress, including at the division's final edge, is ignored. The running result and its done timing are unchanged, and no error is raised.
- R9: A start presented in the cycle in which done is high is accepted and begins a new calculation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, one cycle |
| fref_hz_i | input | 32 | Reference frequency in hertz |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Out-of-range flag, high with done |
| ndiv_o | output | 7 | Integer divider |
| frac_o | output | 16 | Fractional divider |
| word_o | output | 32 | Packed PLL configuration word |

## Verification
The completion of one calculation and the acceptance of the next start can fall in the same cycle. The bench drives a new start exactly in the cycle in which done is high and expects that start to be accepted. It also drives a start one cycle earlier, so that it is sampled on the divider's final edge, and expects that start to be dropped. A behavioural model counts cycles from each accepted start. On every clock it predicts done, error, NDIV, FRAC and the word, so that a one-cycle shift in either direction, or a swallowed or duplicated start, shows up as a mismatch.

// File: rtl/pll_calc_pkg.sv
package pll_calc_pkg;
   localparam int NDIV_W      = 7;
   localparam int FRAC_W      = 16;
   localparam int WORD_W      = 32;
   localparam int NDIV_LSB    = 0;
   localparam int FRAC_LSB    = 10;
   localparam int BIT_ENABLE  = 26;
   localparam int BIT_STRBYP  = 28;
   localparam int BIT_FRACCTL = 29;
   localparam int BIT_DITH0   = 30;
   localparam int BIT_DITH1   = 31;

   typedef struct packed {
      logic [NDIV_W-1:0] ndiv;
      logic [FRAC_W-1:0] frac;
   } pll_div_t;
endpackage

// File: rtl/pll_ref_range.sv
module pll_ref_range #(
   parameter int              FIN_W  = 32,
   parameter longint unsigned MIN_HZ = 64'd19_200_000,
   parameter longint unsigned MAX_HZ = 64'd38_400_000
) (
   input  logic [FIN_W-1:0] fref_i,
   output logic             ok_o
);
   localparam longint unsigned FIN_MAX = (64'd1 << FIN_W) - 64'd1;
   localparam logic [FIN_W-1:0] LO = FIN_W'(MIN_HZ);
   localparam logic [FIN_W-1:0] HI = FIN_W'(MAX_HZ);

   logic lo_ok, hi_ok;

   generate
      if (MIN_HZ == 64'd0) begin : g_no_lo
         assign lo_ok = 1'b1;
      end else begin : g_lo
         assign lo_ok = (fref_i >= LO);
      end
      if (MAX_HZ >= FIN_MAX) begin : g_no_hi
         assign hi_ok = 1'b1;
      end else begin : g_hi
         assign hi_ok = (fref_i <= HI);
      end
   endgenerate

   assign ok_o = lo_ok && hi_ok;
endmodule

// File: rtl/pll_restoring_div.sv
module pll_restoring_div #(
   parameter int DVD_W = 48,
   parameter int DVS_W = 33,
   parameter int Q_W   = 23
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic             load_i,
   input  logic [DVD_W-1:0] dividend_i,
   input  logic [DVS_W-1:0] divisor_i,
   output logic             busy_o,
   output logic             fin_o,
   output logic [Q_W-1:0]   quot_o
);
   localparam int CNT_W = $clog2(DVD_W + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DVD_W - 1);

   generate
      if (Q_W > DVD_W) begin : g_bad_qw
         $error("quotient slice wider than dividend");
      end
   endgenerate

   logic [DVD_W-1:0] work_q;
   logic [DVS_W-1:0] rem_q, dvs_q;
   logic [CNT_W-1:0] cnt_q;
   logic             busy_q, fin_q;
   logic [Q_W-1:0]   quot_q;

   logic [DVS_W:0]   trial, diff;
   logic             ge;
   logic [DVS_W-1:0] rem_nx;
   logic [DVD_W-1:0] work_nx;

   always_comb begin
      trial   = {rem_q, work_q[DVD_W-1]};
      ge      = (trial >= {1'b0, dvs_q});
      diff    = trial - {1'b0, dvs_q};
      rem_nx  = ge ? diff[DVS_W-1:0] : trial[DVS_W-1:0];
      work_nx = {work_q[DVD_W-2:0], ge};
   end

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         work_q <= '0;
         rem_q  <= '0;
         dvs_q  <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
         fin_q  <= 1'b0;
         quot_q <= '0;
      end else begin
         fin_q <= 1'b0;
         if (!busy_q) begin
            if (load_i) begin
               work_q <= dividend_i;
               rem_q  <= '0;
               dvs_q  <= divisor_i;
               cnt_q  <= '0;
               busy_q <= 1'b1;
            end
         end else begin
            work_q <= work_nx;
            rem_q  <= rem_nx;
            cnt_q  <= cnt_q + 1'b1;
            if (cnt_q == LAST) begin
               busy_q <= 1'b0;
               fin_q  <= 1'b1;
               quot_q <= work_nx[Q_W-1:0];
            end
         end
      end
   end

   assign busy_o = busy_q;
   assign fin_o  = fin_q;
   assign quot_o = quot_q;

   assert_load_starts_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (load_i && !busy_o) |=> busy_o);
   assert_fin_closes_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      fin_o |-> (!busy_o && $past(busy_o)));
   assert_count_bounded_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      busy_q |-> (cnt_q <= LAST));
   assert_nonzero_divisor_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (load_i && !busy_o) |-> (divisor_i != '0));
endmodule

// File: rtl/pll_word_pack.sv
module pll_word_pack
   import pll_calc_pkg::*;
(
   input  pll_div_t            div_i,
   output logic [WORD_W-1:0]   word_o
);
   always_comb begin
      word_o = '0;
      word_o[BIT_DITH1]  = 1'b1;
      word_o[BIT_DITH0]  = 1'b1;
      word_o[BIT_STRBYP] = 1'b1;
      word_o[BIT_ENABLE] = 1'b0;
      word_o[NDIV_LSB +: NDIV_W] = div_i.ndiv;
      if (div_i.frac != '0) begin
         word_o[BIT_FRACCTL] = 1'b1;
         word_o[FRAC_LSB +: FRAC_W] = div_i.frac;
      end
   end
endmodule

// File: rtl/pll_word_calc.sv
module pll_word_calc
   import pll_calc_pkg::*;
#(
   parameter int              FIN_W       = 32,
   parameter longint unsigned FVCO_HZ     = 64'd2_880_000_000,
   parameter longint unsigned FREF_MIN_HZ = 64'd19_200_000,
   parameter longint unsigned FREF_MAX_HZ = 64'd38_400_000
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              start_i,
   input  logic [FIN_W-1:0]  fref_hz_i,
   output logic              done_o,
   output logic              err_o,
   output logic [6:0]        ndiv_o,
   output logic [15:0]       frac_o,
   output logic [31:0]       word_o
);
   localparam int DVS_W = FIN_W + 1;
   localparam int DVD_W = $clog2(FVCO_HZ + 64'd1) + FRAC_W;
   localparam int Q_W   = NDIV_W + FRAC_W;
   localparam logic [DVD_W-1:0] DIVIDEND = DVD_W'(FVCO_HZ << FRAC_W);
   localparam logic [NDIV_W-1:0] NDIV_LO = NDIV_W'(FVCO_HZ / (64'd2 * FREF_MAX_HZ));
   localparam logic [NDIV_W-1:0] NDIV_HI = NDIV_W'(FVCO_HZ / (64'd2 * FREF_MIN_HZ));

   generate
      if (FREF_MIN_HZ == 64'd0 || FREF_MIN_HZ > FREF_MAX_HZ) begin : g_bad_window
         $error("reference window must be non-empty and exclude zero");
      end
      if ((FVCO_HZ / (64'd2 * FREF_MIN_HZ)) >= (64'd1 << NDIV_W)) begin : g_bad_ndiv
         $error("integer divider overflows its field");
      end
      if (DVD_W > 64) begin : g_bad_dvd
         $error("dividend too wide");
      end
   endgenerate

   logic     range_ok, div_busy, div_fin, accept, err_q;
   logic [Q_W-1:0] quot;
   pll_div_t result;

   pll_ref_range #(
      .FIN_W  (FIN_W),
      .MIN_HZ (FREF_MIN_HZ),
      .MAX_HZ (FREF_MAX_HZ)
   ) range_i (
      .fref_i (fref_hz_i),
      .ok_o   (range_ok)
   );

   assign accept = start_i && !div_busy;

   pll_restoring_div #(
      .DVD_W (DVD_W),
      .DVS_W (DVS_W),
      .Q_W   (Q_W)
   ) div_i (
      .clk_i      (clk_i),
      .rst_n_i    (rst_n_i),
      .load_i     (accept && range_ok),
      .dividend_i (DIVIDEND),
      .divisor_i  ({fref_hz_i, 1'b0}),
      .busy_o     (div_busy),
      .fin_o      (div_fin),
      .quot_o     (quot)
   );

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) err_q <= 1'b0;
      else          err_q <= accept && !range_ok;
   end

   assign result.ndiv = quot[FRAC_W +: NDIV_W];
   assign result.frac = quot[FRAC_W-1:0];

   pll_word_pack pack_i (
      .div_i  (result),
      .word_o (word_o)
   );

   assign ndiv_o = result.ndiv;
   assign frac_o = result.frac;
   assign done_o = err_q | div_fin;
   assign err_o  = err_q;

   assert_fin_one_cycle_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      div_fin |=> !div_fin);
   assert_err_keeps_word_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      err_o |-> $stable(word_o));
   assert_fracctl_tracks_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (done_o && !err_o) |-> (word_o[BIT_FRACCTL] == (frac_o != '0)));
   assert_ndiv_window_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      div_fin |-> (ndiv_o >= NDIV_LO && ndiv_o <= NDIV_HI));
   assert_fixed_bits_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      done_o |-> (word_o[BIT_DITH1] && word_o[BIT_DITH0] && word_o[BIT_STRBYP] && !word_o[BIT_ENABLE]));
   assert_busy_start_no_err_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (start_i && div_busy) |=> !err_o);
endmodule

// File: tb/pll_word_calc_tb.sv
`timescale 1ns/1ps
module pll_word_calc_tb_top;
   logic        clk = 1'b0;
   logic        rst_n, start;
   logic [31:0] fref;
   logic        done, err;
   logic [6:0]  ndiv;
   logic [15:0] frac;
   logic [31:0] word;

   always #2 clk = ~clk;

   pll_word_calc dut_i (
      .clk_i (clk), .rst_n_i (rst_n), .start_i (start), .fref_hz_i (fref),
      .done_o (done), .err_o (err), .ndiv_o (ndiv), .frac_o (frac), .word_o (word)
   );

   int n_chk = 0;
   int n_err = 0;

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   function automatic logic [31:0] exp_word(input logic [6:0] n, input logic [15:0] f);
      logic [31:0] w;
      w = 32'hD000_0000 | {25'd0, n};
      if (f != 16'd0) w = w | (32'd1 << 29) | ({16'd0, f} << 10);
      return w;
   endfunction

   // behavioural reference model, advanced on every rising edge
   int              m_cnt;
   bit              m_done, m_err;
   logic [6:0]      m_ndiv, p_ndiv;
   logic [15:0]     m_frac, p_frac;
   longint unsigned q;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_done = 0; m_err = 0; m_ndiv = '0; m_frac = '0;
      end else begin
         m_done = 0; m_err = 0;
         if (m_cnt > 0) begin
            m_cnt--;
            if (m_cnt == 0) begin
               m_done = 1; m_ndiv = p_ndiv; m_frac = p_frac;
            end
         end else if (start) begin
            if (fref < 32'd19_200_000 || fref > 32'd38_400_000) begin
               m_done = 1; m_err = 1;
            end else begin
               m_cnt = 48;
               q = (64'd2_880_000_000 << 16) / (64'(fref) * 64'd2);
               p_ndiv = q[22:16];
               p_frac = q[15:0];
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         check(done == m_done, "R7 done", done, m_done);
         check(err == m_err, "R6 err", err, m_err);
         check(ndiv == m_ndiv, "R2 ndiv", ndiv, m_ndiv);
         check(frac == m_frac, "R3 frac", frac, m_frac);
         check(word == exp_word(m_ndiv, m_frac), "R5 word", word, exp_word(m_ndiv, m_frac));
      end
   end

   task automatic go(input logic [31:0] f);
      @(negedge clk); start = 1'b1; fref = f;
      @(negedge clk); start = 1'b0;
      for (int i = 0; i < 60 && !done; i++) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] held;
      rst_n = 1'b0; start = 1'b0; fref = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!done && !err && ndiv == 0 && frac == 0, "R1 reset outputs", {done, err, ndiv, frac}, 0);
      check(word == 32'hD000_0000, "R1 reset word", word, 32'hD000_0000);

      go(32'd24_000_000);
      check(done && !err, "R7 done no err", {done, err}, 2'b10);
      check(ndiv == 7'd60 && frac == 0, "R2 24MHz", {ndiv, frac}, {7'd60, 16'd0});
      check(word == 32'hD000_003C, "R5 24MHz word", word, 32'hD000_003C);
      check(word[31] && word[30] && word[28] && !word[26], "R4 fixed bits", word, 32'hD000_0000);

      go(32'd19_200_000);
      check(ndiv == 7'd75 && frac == 0, "R2 lower bound", {ndiv, frac}, {7'd75, 16'd0});

      go(32'd38_400_000);
      check(ndiv == 7'd37 && frac == 16'h8000, "R3 upper bound", {ndiv, frac}, {7'd37, 16'h8000});
      check(word == 32'hF200_0025, "R5 fracctl word", word, 32'hF200_0025);

      go(32'd25_000_000);
      check(frac == 16'd39321, "R3 25MHz frac", frac, 16'd39321);
      go(32'd26_000_000);
      go(32'd33_333_333);

      held = word;
      go(32'd19_199_999);
      check(done && err, "R6 below min", {done, err}, 2'b11);
      check(word == held, "R6 word held", word, held);
      go(32'd38_400_001);
      check(done && err, "R6 above max", {done, err}, 2'b11);
      go(32'd0);
      check(err && word == held, "R6 zero", word, held);
      go(32'hFFFF_FFFF);
      check(err && word == held, "R6 all ones", word, held);

      // R8: starts during the division, including on its last edge, are dropped
      @(negedge clk); start = 1'b1; fref = 32'd24_000_000;
      @(negedge clk); start = 1'b0;
      repeat (10) @(negedge clk);
      start = 1'b1; fref = 32'd1;
      @(negedge clk); start = 1'b0;
      repeat (36) @(negedge clk);
      start = 1'b1; fref = 32'd26_000_000;
      @(negedge clk);
      check(done && !err && ndiv == 7'd60, "R8 ignored starts", {done, err, ndiv}, {2'b10, 7'd60});
      // R9: start in the done cycle is taken
      start = 1'b1; fref = 32'd38_400_000;
      @(negedge clk); start = 1'b0;
      check(!done, "R9 done single", done, 0);
      for (int i = 0; i < 60 && !done; i++) @(negedge clk);
      check(done && ndiv == 7'd37 && frac == 16'h8000, "R9 accepted in done cycle", {ndiv, frac}, {7'd37, 16'h8000});

      repeat (5) @(negedge clk);
      summary();
      $finish;
   end
endmodule